// File: doc/BRIEF.md
# Addressed Frame Receive Gate

This block sits between a host character receiver and a display terminal's data path. It watches every incoming character and decides which ones reach the display. A start-of-text character arms the gate. The next character is then compared with the terminal's own address and with a shared broadcast address. When either one matches, a receive-enable window opens. Every character after the address character then flows through a three-stage character pipeline to the output. The window closes when the end-of-text character reaches the last stage.

Several terminals can share one host line, so every terminal arms on start-of-text whatever address follows. Only the addressed terminals open their windows. Nothing is accepted while the terminal is itself transmitting. A start-of-text that arrives while the window is open restarts the address check.

Top module: `addr_frame_gate`

## Requirements
- R1: A synchronous active-high reset clears both gate flags and all three pipeline stages. After reset, `rx_enable` and `out_valid` are 0, and a frame that was open before the reset forwards no further characters.
- R2: When the byte 0x02 is received and the next received byte equals `own_addr`, `rx_enable` goes high. Every byte after the address is then forwarded in arrival order on `out_byte`, with one `out_valid` pulse for each byte. `out_valid` is never high while `rx_enable` is low.
- R3: An address byte equal to `bcast_addr` opens the gate in the same way as `own_addr`.
- R4: When the byte after 0x02 matches neither address, both flags clear and `rx_enable` never rises. Nothing from that frame is forwarded, and a later valid frame is accepted normally.
- R5: Neither the 0x02 byte nor the address byte appears on the output. `out_valid` is low in the cycle in which `rx_enable` first rises.
- R6: The end-of-text byte 0x03 is forwarded as the last byte of a frame. `rx_enable` is low in the cycle after 0x03 is presented on the output. Bytes received after 0x03 are not forwarded.
- R7: While `tx_active` is high, incoming bytes are ignored and `rx_enable` is low from the next cycle on. A frame that was open when `tx_active` rose stays closed afterwards.
- R8: A 0x02 byte received while the gate is open makes `rx_enable` low two cycles after its capture edge. That 0x02 is not forwarded, and the byte that follows it is checked as a new address.
- R9: A forwarded byte that is captured on clock edge N is presented with `out_valid` high right after edge N+2, for exactly one cycle.
- R10: While armed and waiting for the address, idle cycles (`rx_valid` low) change nothing. The next valid byte is the one taken as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received character from the host |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| tx_active | input | 1 | Terminal is transmitting; receive is blocked |
| own_addr | input | 8 | This terminal's address code |
| bcast_addr | input | 8 | Address code accepted by all terminals |
| out_byte | output | 8 | Character forwarded to the display path |
| out_valid | output | 1 | One-cycle strobe marking `out_byte` valid |
| rx_enable | output | 1 | Receive-enable window level |

## Verification
The two flags can only be seen through `rx_enable` and through which bytes are forwarded. A flag left stuck at 1 shows up as a frame that keeps forwarding after its 0x03, or as an address that is accepted without a preceding 0x02. A flag that never sets shows up as an empty output sequence. Either fault is visible within three cycles of the deciding byte, because that is the pipeline length. The directed frames therefore compare the complete forwarded byte sequence, and they sample `rx_enable` at the exact cycle in which it should change.

// File: rtl/afg_pkg.sv
package afg_pkg;

    localparam int CHAR_W     = 8;
    localparam int PIPE_DEPTH = 3;

    typedef logic [CHAR_W-1:0] char_code_t;

    localparam char_code_t CODE_STX = 8'h02;
    localparam char_code_t CODE_ETX = 8'h03;

    // One character slot of the receive pipeline
    typedef struct packed {
        logic       vld;
        char_code_t code;
    } pipe_slot_t;

    // Arm-then-address handshake state
    typedef struct packed {
        logic armed;
        logic addressed;
    } gate_flags_t;

    function automatic logic slot_holds(input pipe_slot_t s, input char_code_t c);
        return s.vld && (s.code == c);
    endfunction

endpackage

// File: rtl/afg_addr_match.sv
module afg_addr_match #(
    parameter int W = afg_pkg::CHAR_W
) (
    input  logic [W-1:0] code,
    input  logic [W-1:0] own_code,
    input  logic [W-1:0] shared_code,
    output logic         hit
);
    always_comb begin
        hit = (code == own_code) || (code == shared_code);
    end
endmodule

// File: rtl/afg_char_pipe.sv
module afg_char_pipe
    import afg_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  char_code_t in_code,
    input  logic       advance,
    output pipe_slot_t head,
    output pipe_slot_t tail
);
    localparam int LAST = DEPTH - 1;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stg
        pipe_slot_t q;
        if (k == 0) begin : g_entry
            // Entry stage loads every accepted character
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q.vld <= in_vld;
                    if (in_vld) q.code <= in_code;
                end
            end
        end else begin : g_later
            // Later stages move only while the window lets them
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q.vld <= g_stg[k-1].q.vld && advance;
                    if (g_stg[k-1].q.vld && advance) q.code <= g_stg[k-1].q.code;
                end
            end
        end
    end

    assign head = g_stg[0].q;
    assign tail = g_stg[LAST].q;
endmodule

// File: rtl/afg_gate_ctrl.sv
module afg_gate_ctrl
    import afg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_active,
    input  pipe_slot_t head,
    input  pipe_slot_t tail,
    input  logic       addr_hit,
    output logic       rx_enable,
    output logic       advance
);
    gate_flags_t flags_q;
    gate_flags_t flags_d;
    logic        restart;
    logic        closing;
    logic        awaiting;

    always_comb begin
        restart   = slot_holds(head, CODE_STX);
        rx_enable = flags_q.armed && flags_q.addressed;
        closing   = slot_holds(tail, CODE_ETX) && rx_enable;
        awaiting  = flags_q.armed && !flags_q.addressed;
        advance   = rx_enable && !tx_active && !restart && !closing;
    end

    // Priority: transmit block, restart, end of frame, address decision
    always_comb begin
        flags_d = flags_q;
        if (tx_active) begin
            flags_d = '0;
        end else if (restart) begin
            flags_d.armed     = 1'b1;
            flags_d.addressed = 1'b0;
        end else if (closing) begin
            flags_d = '0;
        end else if (awaiting && head.vld) begin
            if (addr_hit) flags_d.addressed = 1'b1;
            else          flags_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end
endmodule

// File: rtl/addr_frame_gate.sv
module addr_frame_gate
    import afg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              tx_active,
    input  logic [CHAR_W-1:0] own_addr,
    input  logic [CHAR_W-1:0] bcast_addr,
    output logic [CHAR_W-1:0] out_byte,
    output logic              out_valid,
    output logic              rx_enable
);
    pipe_slot_t head;
    pipe_slot_t tail;
    logic       take;
    logic       advance;
    logic       addr_hit;

    assign take = rx_valid && !tx_active;

    afg_char_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (take),
        .in_code (rx_byte),
        .advance (advance),
        .head    (head),
        .tail    (tail)
    );

    afg_addr_match #(.W(CHAR_W)) u_match (
        .code        (head.code),
        .own_code    (own_addr),
        .shared_code (bcast_addr),
        .hit         (addr_hit)
    );

    afg_gate_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tx_active (tx_active),
        .head      (head),
        .tail      (tail),
        .addr_hit  (addr_hit),
        .rx_enable (rx_enable),
        .advance   (advance)
    );

    assign out_byte  = tail.code;
    assign out_valid = tail.vld;
endmodule

// File: rtl/afg_checker.sv
module afg_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       tx_active,
    input logic [7:0] out_byte,
    input logic       out_valid,
    input logic       rx_enable
);
    // R2
    fwd_inside_window_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> rx_enable);

    // R5
    open_without_output_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_enable) |-> !out_valid);

    // R6
    etx_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_byte == 8'h03) |=> !rx_enable);

    // R7
    tx_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        tx_active |=> !rx_enable);

    // R8
    stx_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !tx_active && rx_byte == 8'h02) |=> ##1 !rx_enable);
endmodule

bind addr_frame_gate afg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .tx_active (tx_active),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .rx_enable (rx_enable)
);

// File: tb/addr_frame_gate_tb.sv
module addr_frame_gate_tb;
    localparam logic [7:0] STX = 8'h02, ETX = 8'h03, OWN = 8'h41, BC = 8'h7F;

    logic clk = 1'b0, rst = 1'b1;
    logic [7:0] rx_byte = '0;
    logic rx_valid = 1'b0, tx_active = 1'b0;
    logic [7:0] out_byte;
    logic out_valid, rx_enable;
    int checks = 0, errors = 0;
    logic [7:0] got[$];
    logic [7:0] exp_q[$];
    bit saw_en = 1'b0;

    always #5 clk = ~clk;

    addr_frame_gate u_dut (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_active(tx_active), .own_addr(OWN), .bcast_addr(BC),
        .out_byte(out_byte), .out_valid(out_valid), .rx_enable(rx_enable)
    );

    always @(negedge clk) if (!rst) begin
        if (out_valid) got.push_back(out_byte);
        if (rx_enable) saw_en = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_seq(input string req);
        chk(got.size() == exp_q.size(), req, "forwarded count", got.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < got.size()) chk(got[i] == exp_q[i], req, "forwarded byte", got[i], exp_q[i]);
        got.delete(); exp_q.delete(); saw_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(3);
        chk(rx_enable == 1'b0, "R1", "rx_enable in reset", rx_enable, 0);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst = 1'b0; idle(2);
    endtask

    task automatic t_own_frame();
        put(STX); put(OWN); idle(2);
        chk(rx_enable == 1'b1, "R2", "rx_enable open", rx_enable, 1);
        put(8'h48); put(8'h49); put(ETX); idle(4);
        chk(rx_enable == 1'b0, "R6", "rx_enable after ETX", rx_enable, 0);
        idle(2);
        exp_q = '{8'h48, 8'h49, ETX};
        expect_seq("R2 R5 R6");
    endtask

    task automatic t_bcast_frame();
        put(STX); put(BC); put(8'h5A); put(ETX); idle(6);
        exp_q = '{8'h5A, ETX};
        expect_seq("R3");
    endtask

    task automatic t_wrong_addr();
        put(STX); put(8'h55); put(8'h51); put(ETX); idle(6);
        chk(saw_en == 1'b0, "R4", "rx_enable seen for wrong address", saw_en, 0);
        expect_seq("R4");
        put(STX); put(OWN); put(8'h31); put(ETX); idle(6);
        exp_q = '{8'h31, ETX};
        expect_seq("R4 recovery");
    endtask

    task automatic t_gaps();
        put(STX); idle(3); put(OWN); idle(2); put(8'h61); idle(1); put(ETX); idle(6);
        exp_q = '{8'h61, ETX};
        expect_seq("R10");
    endtask

    task automatic t_after_etx();
        put(STX); put(OWN); put(8'h6D); put(ETX); put(8'h6E); put(8'h6F); idle(6);
        chk(rx_enable == 1'b0, "R6", "rx_enable after trailing bytes", rx_enable, 0);
        exp_q = '{8'h6D, ETX};
        expect_seq("R6 trailing");
    endtask

    task automatic t_latency();
        put(STX); put(OWN); idle(2);
        rx_byte = 8'h4B; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk(out_valid == 1'b0, "R9", "out_valid one edge", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid two edges", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_byte == 8'h4B, "R9", "byte three edges",
            {out_valid, out_byte}, {1'b1, 8'h4B});
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "single pulse", out_valid, 0);
        put(ETX); idle(6);
        exp_q = '{8'h4B, ETX};
        expect_seq("R9");
    endtask

    task automatic t_transmit();
        tx_active = 1'b1;
        put(STX); put(OWN); put(8'h78); put(ETX); idle(3);
        tx_active = 1'b0; idle(3);
        chk(saw_en == 1'b0, "R7", "rx_enable while transmitting", saw_en, 0);
        expect_seq("R7 blocked");
        put(STX); put(OWN); idle(2);
        chk(rx_enable == 1'b1, "R7", "window before transmit", rx_enable, 1);
        tx_active = 1'b1; idle(1);
        chk(rx_enable == 1'b0, "R7", "window after transmit", rx_enable, 0);
        tx_active = 1'b0;
        put(8'h77); put(ETX); idle(6);
        expect_seq("R7 closed");
    endtask

    task automatic t_restart();
        put(STX); put(OWN); put(8'h61); idle(3);
        put(STX); idle(1);
        chk(rx_enable == 1'b0, "R8", "rx_enable after restart", rx_enable, 0);
        put(BC); put(8'h62); put(ETX); idle(6);
        exp_q = '{8'h61, 8'h62, ETX};
        expect_seq("R8");
        put(STX); put(OWN); idle(2);
        put(STX); put(8'h10); put(8'h63); put(ETX); idle(6);
        expect_seq("R8 bad readdress");
    endtask

    task automatic t_mid_reset();
        put(STX); put(OWN); idle(2);
        rst = 1'b1; idle(1);
        chk(rx_enable == 1'b0, "R1", "rx_enable after reset", rx_enable, 0);
        rst = 1'b0;
        put(8'h71); put(ETX); idle(6);
        expect_seq("R1 frame dropped");
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_own_frame();
        t_bcast_frame();
        t_wrong_addr();
        t_gaps();
        t_after_etx();
        t_latency();
        t_transmit();
        t_restart();
        t_mid_reset();
        report();
    end
endmodule